// File: doc/BRIEF.md
# Tree-Structured Unsigned Magnitude Comparator

This block compares two unsigned operands of N bits, `x_op` and `y_op`, and raises exactly one of three flags: less-than, greater-than or equal. It is purely combinational. It has no clock and no storage, and the flags follow the operands after the delay of the logic.

The comparison is built as a balanced binary tree from one kind of 2-bit node. Each leaf compares one aligned pair of operand bits. Each node above the leaves combines two child results, treating each child's (greater, less) pair as a 2-bit operand. The more significant child sits in the high position and the less significant child in the low position. The logic path therefore grows with log2(N) node levels rather than with N.

Each node forms its products with a three-input primitive `r = a & ~b ^ c`. Where two terms can never be true together, the node merges them with XOR instead of OR. A small output stage turns the root pair into the three flags.

Top module: `mag_cmp_tree`

## Requirements
- R1: `lt_o` is 1 exactly when `x_op` is smaller than `y_op`, with both operands read as unsigned binary numbers.
- R2: `gt_o` is 1 exactly when `x_op` is larger than `y_op`, with both operands read as unsigned.
- R3: `eq_o` is 1 exactly when every bit of `x_op` matches the bit at the same position in `y_op`.
- R4: For every operand pair, exactly one of `lt_o`, `gt_o` and `eq_o` is 1.
- R5: When the operands differ in bit N-1, that bit alone decides the result: `gt_o` equals `x_op[N-1]` and `lt_o` equals `y_op[N-1]`, whatever the lower bits hold.
- R6: When the operands differ only in bit 0, the result follows that bit: `gt_o` is 1 if `x_op[0]` is 1, and otherwise `lt_o` is 1.
- R7: Two all-zero operands give `eq_o` = 1, and two all-ones operands give `eq_o` = 1.
- R8: N must be a power of two and at least 2, and the node tree has log2(N) levels counted from the leaves up to the root.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_op | input | N | First unsigned operand |
| y_op | input | N | Second unsigned operand |
| lt_o | output | 1 | High when x_op < y_op |
| gt_o | output | 1 | High when x_op > y_op |
| eq_o | output | 1 | High when x_op == y_op |

## Verification
The hardest case to reach is a decision made in the lowest bit pair that has to travel through every tree level to the root. This only happens when all higher pairs compare equal. For wide operands, uniform random values almost never produce it. The stimulus therefore builds operand pairs that differ in exactly one chosen bit, including bit 0 and bit N-1, and adds all-zeros and all-ones pairs. Widths 4 and 8 are also swept over every operand pair, so each node-level combination is covered at those sizes.

// File: rtl/cmp_tree_pkg.sv
package cmp_tree_pkg;

    // One bit of each operand at the same rank: the x-side and the y-side.
    typedef struct packed {
        logic xb;
        logic yb;
    } bit_pair_t;

    // Partial comparison result carried up the tree.
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_res_t;

    // First node index of tree level lvl (level 0 = leaves) in a flat array.
    function automatic int lvl_base(input int n, input int lvl);
        return n - (n >> lvl);
    endfunction

    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/cmp_prim.sv
// Three-input primitive: r = a AND NOT b, XOR c.
module cmp_prim (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic r_o
);
    assign r_o = (a_i & ~b_i) ^ c_i;
endmodule

// File: rtl/cmp_node.sv
// 2-bit comparison node; every product term goes through cmp_prim.
module cmp_node
    import cmp_tree_pkg::*;
(
    input  bit_pair_t hi_i,
    input  bit_pair_t lo_i,
    output cmp_res_t  res_o
);
    logic hi_same;
    logic lo_gt_raw, lo_lt_raw;
    logic lo_gt_gate, lo_lt_gate;
    logic gt_w, lt_w;

    assign hi_same = ~(hi_i.xb ^ hi_i.yb);

    // Low-rank products with c tied low.
    cmp_prim u_lo_gt (.a_i(lo_i.xb), .b_i(lo_i.yb), .c_i(1'b0), .r_o(lo_gt_raw));
    cmp_prim u_lo_lt (.a_i(lo_i.yb), .b_i(lo_i.xb), .c_i(1'b0), .r_o(lo_lt_raw));

    // Qualify by equality of the high rank.
    cmp_prim u_q_gt (.a_i(lo_gt_raw), .b_i(~hi_same), .c_i(1'b0), .r_o(lo_gt_gate));
    cmp_prim u_q_lt (.a_i(lo_lt_raw), .b_i(~hi_same), .c_i(1'b0), .r_o(lo_lt_gate));

    // High-rank term XOR qualified low term (terms are mutually exclusive).
    cmp_prim u_gt (.a_i(hi_i.xb), .b_i(hi_i.yb), .c_i(lo_gt_gate), .r_o(gt_w));
    cmp_prim u_lt (.a_i(hi_i.yb), .b_i(hi_i.xb), .c_i(lo_lt_gate), .r_o(lt_w));

    assign res_o.gt = gt_w;
    assign res_o.lt = lt_w;
endmodule

// File: rtl/cmp_flag_stage.sv
// Turns the root pair into three one-hot flags.
module cmp_flag_stage
    import cmp_tree_pkg::*;
(
    input  cmp_res_t root_i,
    output logic     lt_o,
    output logic     gt_o,
    output logic     eq_o
);
    logic gt_n;

    assign gt_n = ~root_i.gt;
    cmp_prim u_eq (.a_i(gt_n), .b_i(root_i.lt), .c_i(1'b0), .r_o(eq_o));

    assign lt_o = root_i.lt;
    assign gt_o = root_i.gt;
endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree
    import cmp_tree_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] x_op,
    input  logic [N-1:0] y_op,
    output logic         lt_o,
    output logic         gt_o,
    output logic         eq_o
);
    localparam int LEAVES = N / 2;
    localparam int LEVELS = $clog2(N);   // leaf level included
    localparam int NODES  = N - 1;
    localparam int ROOT   = N - 2;

    // R8: width legality
    if (!is_pow2(N)) begin : g_bad_width
        $error("mag_cmp_tree: N must be a power of two >= 2");
    end

    cmp_res_t node_res [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        bit_pair_t hp, lp;
        assign hp = '{xb: x_op[2*i+1], yb: y_op[2*i+1]};
        assign lp = '{xb: x_op[2*i],   yb: y_op[2*i]};
        cmp_node u_node (.hi_i(hp), .lo_i(lp), .res_o(node_res[i]));
    end

    for (genvar l = 1; l < LEVELS; l++) begin : g_lvl
        localparam int CB = lvl_base(N, l - 1);
        localparam int OB = lvl_base(N, l);
        for (genvar j = 0; j < (N >> (l + 1)); j++) begin : g_nd
            bit_pair_t hp, lp;
            assign hp = '{xb: node_res[CB+2*j+1].gt, yb: node_res[CB+2*j+1].lt};
            assign lp = '{xb: node_res[CB+2*j].gt,   yb: node_res[CB+2*j].lt};
            cmp_node u_node (.hi_i(hp), .lo_i(lp), .res_o(node_res[OB+j]));
        end
    end

    cmp_flag_stage u_flags (
        .root_i (node_res[ROOT]),
        .lt_o   (lt_o),
        .gt_o   (gt_o),
        .eq_o   (eq_o)
    );
endmodule

// File: rtl/mag_cmp_tree_chk.sv
module mag_cmp_tree_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] x_op,
    input logic [N-1:0] y_op,
    input logic         lt_o,
    input logic         gt_o,
    input logic         eq_o
);
    always_comb begin
        // R1
        lt_match_chk: assert (lt_o == (x_op < y_op));
        // R2
        gt_match_chk: assert (gt_o == (x_op > y_op));
        // R3
        eq_match_chk: assert (eq_o == (x_op == y_op));
        // R4
        one_flag_chk: assert ($countones({lt_o, gt_o, eq_o}) == 1);
        // R5
        msb_rule_chk: assert ((x_op[N-1] == y_op[N-1]) ||
                              (gt_o == x_op[N-1] && lt_o == y_op[N-1]));
        // R6
        lsb_rule_chk: assert ((x_op[N-1:1] != y_op[N-1:1]) ||
                              (gt_o == (x_op[0] & ~y_op[0]) && lt_o == (~x_op[0] & y_op[0])));
    end
endmodule

bind mag_cmp_tree mag_cmp_tree_chk #(.N(N)) u_chk (
    .x_op (x_op),
    .y_op (y_op),
    .lt_o (lt_o),
    .gt_o (gt_o),
    .eq_o (eq_o)
);

// File: tb/test_mag_cmp_tree.sv
module test_mag_cmp_tree;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0]  x4,  y4;
    logic [7:0]  x8,  y8;
    logic [15:0] x16, y16;
    logic [31:0] x32, y32;
    logic lt4, gt4, eq4, lt8, gt8, eq8, lt16, gt16, eq16, lt32, gt32, eq32;

    mag_cmp_tree #(.N(4))  i_mag_cmp_tree_w4  (.x_op(x4),  .y_op(y4),  .lt_o(lt4),  .gt_o(gt4),  .eq_o(eq4));
    mag_cmp_tree #(.N(8))  i_mag_cmp_tree     (.x_op(x8),  .y_op(y8),  .lt_o(lt8),  .gt_o(gt8),  .eq_o(eq8));
    mag_cmp_tree #(.N(16)) i_mag_cmp_tree_w16 (.x_op(x16), .y_op(y16), .lt_o(lt16), .gt_o(gt16), .eq_o(eq16));
    mag_cmp_tree #(.N(32)) i_mag_cmp_tree_w32 (.x_op(x32), .y_op(y32), .lt_o(lt32), .gt_o(gt32), .eq_o(eq32));

    function automatic logic [2:0] expect_flags(input logic [63:0] a, input logic [63:0] b);
        return {a < b, a > b, a == b};   // {lt, gt, eq}
    endfunction

    task automatic chk(input string ctx, input int w, input logic [63:0] a, input logic [63:0] b,
                       input logic lt, input logic gt, input logic eq);
        logic [2:0] e;
        e = expect_flags(a, b);
        n_checks++;
        if (lt !== e[2] || gt !== e[1] || eq !== e[0] || $countones({lt, gt, eq}) != 1) begin
            n_fail++;
            $display("FAIL %s w=%0d x=%h y=%h got lt/gt/eq=%b%b%b expected %b (R1 lt, R2 gt, R3 eq, R4 one-hot)",
                     ctx, w, a, b, lt, gt, eq, e);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic check_wide(input string ctx);
        step();
        chk(ctx, 16, {48'd0, x16}, {48'd0, y16}, lt16, gt16, eq16);
        chk(ctx, 32, {32'd0, x32}, {32'd0, y32}, lt32, gt32, eq32);
    endtask

    initial begin
        x4 = '0; y4 = '0; x8 = '0; y8 = '0;
        x16 = '0; y16 = '0; x32 = '0; y32 = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state after reset: zero operands, R7 equal
        step();
        chk("R7 zeros idle", 4, 64'd0, 64'd0, lt4, gt4, eq4);
        chk("R7 zeros idle", 8, 64'd0, 64'd0, lt8, gt8, eq8);

        // Exhaustive sweep for widths 8 and 4 (R1 R2 R3 R4)
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk);
            x8 = i[15:8]; y8 = i[7:0];
            if (i < 256) begin
                x4 = i[7:4]; y4 = i[3:0];
            end
            step();
            chk("R1 R2 R3 R4 sweep", 8, {56'd0, x8}, {56'd0, y8}, lt8, gt8, eq8);
            if (i < 256)
                chk("R1 R2 R3 R4 sweep", 4, {60'd0, x4}, {60'd0, y4}, lt4, gt4, eq4);
        end

        // Wide corners: R7 zeros and ones
        @(posedge clk); x16 = '0; y16 = '0; x32 = '0; y32 = '0;
        check_wide("R7 all zeros");
        @(posedge clk); x16 = '1; y16 = '1; x32 = '1; y32 = '1;
        check_wide("R7 all ones");

        // R5: differ only in MSB, lower bits random
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            x16 = 16'($urandom); y16 = x16 ^ 16'h8000;
            x32 = $urandom;      y32 = x32 ^ 32'h8000_0000;
            check_wide("R5 msb only");
        end
        // R5: MSB differs with lower bits opposing
        @(posedge clk);
        x16 = 16'h8000; y16 = 16'h7fff; x32 = 32'h7fff_ffff; y32 = 32'h8000_0000;
        check_wide("R5 msb vs rest");

        // R6: differ only in LSB
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            x16 = 16'($urandom); y16 = x16 ^ 16'h0001;
            x32 = $urandom;      y32 = x32 ^ 32'h1;
            check_wide("R6 lsb only");
        end

        // Single-bit differences at every rank (R1 R2)
        for (int b = 0; b < 32; b++) begin
            @(posedge clk);
            x32 = $urandom; y32 = x32 ^ (32'h1 << b);
            x16 = 16'($urandom); y16 = x16 ^ 16'(32'h1 << (b % 16));
            check_wide("R1 R2 one-bit diff");
        end

        // Constrained random: mix of equal, near and unrelated pairs
        for (int k = 0; k < 3000; k++) begin
            int mode;
            mode = int'($urandom % 4);
            @(posedge clk);
            x16 = 16'($urandom); x32 = $urandom;
            case (mode)
                0: begin y16 = x16; y32 = x32; end
                1: begin y16 = x16 ^ 16'($urandom % 16'h00ff); y32 = x32 ^ ($urandom & 32'h0000_ffff); end
                default: begin y16 = 16'($urandom); y32 = $urandom; end
            endcase
            check_wide("R1 R2 R3 R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired (R1) got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule